// File: doc/BRIEF.md
# Event Timer Register and Counter Block

This block is the software-visible front end of a multi-channel event timer. It decodes a 1 KiB window of 32-bit registers and holds the identification word, the global configuration, the interrupt status word and a 64-bit free-running main counter. It also stores each channel's configuration, comparator and message-route words and presents them as flat vectors. The comparison logic and the interrupt wiring that consume those vectors sit outside this block.

The counter advances by one on every clock while the global enable bit is set, and it freezes when the bit is cleared. Software may load either half of the counter only while the block is disabled. When the enable bit turns on, the block sends a one-cycle arm pulse to every channel whose comparator has been programmed (that is, holds something other than all ones). When the enable bit turns off, it sends a one-cycle disarm pulse to every implemented channel. Channel logic reports events on `irqSet`. Software acknowledges an event by writing a one to its status bit, and the block then returns a one-cycle `irqClear` pulse for that channel.

Only full-word accesses take effect. The implemented channel count is the configured value clamped to the range from 3 to `MAX_CH`.

Top module: `evtimer_regs`

## Requirements
- R1: The identification word at 0x000 reads 0x8086A001 with (channel count - 1) placed in bits 12:8, which is 0x8086A201 for 3 channels. The word at 0x004 reads the tick period in femtoseconds (default 10,000,000).
- R2: The channel count is the configured value clamped to [3, MAX_CH]. Channel n occupies 0x100 + n*0x20, with these word offsets in the group: config low/high at +0x0/+0x4, comparator low/high at +0x8/+0xC, route low/high at +0x10/+0x14. A group with n at or above the channel count reads 0 and ignores writes.
- R3: In the global configuration word at 0x010, bit 0 is enable and bit 1 is legacy routing. All other bits read 0. The word at 0x014 reads 0.
- R4: A channel config low write updates only the bits in mask 0x00007F4E. Bits 4 and 5 always read 1. The config high word reads the route capability constant (default 0x4) and ignores writes.
- R5: The counter (low half at 0x0F0, high half at 0x0F4) increments by one on each clock while enabled, carrying into the high half, and holds its value while disabled. Reads return the value current at the read.
- R6: A write to either counter half takes effect only while enable is 0.
- R7: On a 0-to-1 write of enable, `chArm[i]` pulses for one cycle for each channel whose 64-bit comparator is not all ones. On a 1-to-0 write, `chDisarm` pulses for one cycle on all implemented channels.
- R8: A high `irqSet[i]` sets bit i of the status word at 0x020. Writing a 1 to a set bit clears it and pulses `irqClear[i]` for one cycle. A set arriving in the same cycle as a clear wins.
- R9: Only accesses with `busSize` = 2'b10 have an effect. Other sizes read 0 and write nothing.
- R10: Reads of undefined offsets return 0, and writes to them change nothing.
- R11: Read data is registered. It appears in the cycle after `busRdEn` and holds until the next read.
- R12: After reset, configuration, status, counter and route words are 0, comparators are all ones, and `busRdData`, `chArm`, `chDisarm` and `irqClear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address within the window |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busSize | input | 2 | Access size, 2'b10 = 32-bit word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqSet | input | NumCh | Per-channel event from channel logic |
| globalEnable | output | 1 | Global enable bit |
| legacyRoute | output | 1 | Legacy routing bit |
| counter | output | 64 | Main counter value |
| chCfg | output | NumCh*32 | Channel config words (writable bits) |
| chCmp | output | NumCh*64 | Channel comparators |
| chRoute | output | NumCh*64 | Channel message-route words |
| chArm | output | NumCh | One-cycle arm pulses |
| chDisarm | output | NumCh | One-cycle disarm pulses |
| irqClear | output | NumCh | One-cycle status-acknowledge pulses |

## Verification
The counter-hold property assumes that the counter can only change while the block is disabled if a bus write happened in the previous cycle. The stimulus therefore raises `busWrEn` only inside single-cycle write tasks. The properties also assume that every input is driven to a known value from reset onward. The bench meets this by driving all strobes, `busSize` and `irqSet` low before reset releases, and by changing them only at falling clock edges.

// File: rtl/evtimer_regs_pkg.sv
package evtimer_regs_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;
  localparam int MIN_CH = 3;
  localparam int WIN_CH = 24;   // groups that fit between 0x100 and 0x3FF

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_GCFG   = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_ISR    = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] OFF_CH_BASE = 10'h100;

  localparam logic [4:0] CH_CFG_LO = 5'h00;
  localparam logic [4:0] CH_CFG_HI = 5'h04;
  localparam logic [4:0] CH_CMP_LO = 5'h08;
  localparam logic [4:0] CH_CMP_HI = 5'h0C;
  localparam logic [4:0] CH_RT_LO  = 5'h10;
  localparam logic [4:0] CH_RT_HI  = 5'h14;

  localparam logic [DATA_W-1:0] CAP_BASE     = 32'h8086_A001;
  localparam logic [DATA_W-1:0] CH_CFG_WMASK = 32'h0000_7F4E;
  localparam logic [DATA_W-1:0] CH_CFG_RO    = 32'h0000_0030;
  localparam logic [1:0]        GCFG_WMASK   = 2'b11;

  typedef enum logic [3:0] {
    RD_NONE, RD_CAP_LO, RD_CAP_HI, RD_GCFG, RD_ISR, RD_CNT_LO, RD_CNT_HI,
    RD_CH_CFG_LO, RD_CH_CFG_HI, RD_CH_CMP_LO, RD_CH_CMP_HI, RD_CH_RT_LO, RD_CH_RT_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrGcfg;
    logic   wrIsr;
    logic   wrCntLo;
    logic   wrCntHi;
    logic   wrChCfg;
    logic   wrChCmpLo;
    logic   wrChCmpHi;
    logic   wrChRtLo;
    logic   wrChRtHi;
    logic   rdStb;
    rdSel_e rdSel;
    logic [4:0] chIdx;
  } strobes_t;

  function automatic int clampCh(int cfg, int maxCh);
    int hi;
    hi = (maxCh > WIN_CH) ? WIN_CH : maxCh;
    if (cfg < MIN_CH) return MIN_CH;
    if (cfg > hi) return hi;
    return cfg;
  endfunction

endpackage

// File: rtl/evtimer_regs_ctrl.sv
module evtimer_regs_ctrl
  import evtimer_regs_pkg::*;
#(
  parameter int NumCh = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  output strobes_t          st
);

  localparam logic [4:0] NumChW   = 5'(NumCh);
  localparam logic [4:0] BaseGrp  = OFF_CH_BASE[9:5];

  logic       wordOk;
  logic       inChWin;
  logic       chValid;
  logic [4:0] chIdx;
  logic [4:0] chOff;
  logic       wr;

  assign wordOk  = (busSize == 2'b10);
  assign inChWin = (busAddr >= OFF_CH_BASE);
  assign chIdx   = busAddr[9:5] - BaseGrp;
  assign chOff   = busAddr[4:0];
  assign chValid = inChWin && (chIdx < NumChW);
  assign wr      = busWrEn && wordOk;

  always_comb begin
    st = '0;
    st.rdSel = RD_NONE;
    st.chIdx = chIdx;
    st.rdStb = busRdEn;
    if (chValid) begin
      unique case (chOff)
        CH_CFG_LO: begin st.wrChCfg   = wr; st.rdSel = RD_CH_CFG_LO; end
        CH_CFG_HI: begin                    st.rdSel = RD_CH_CFG_HI; end
        CH_CMP_LO: begin st.wrChCmpLo = wr; st.rdSel = RD_CH_CMP_LO; end
        CH_CMP_HI: begin st.wrChCmpHi = wr; st.rdSel = RD_CH_CMP_HI; end
        CH_RT_LO:  begin st.wrChRtLo  = wr; st.rdSel = RD_CH_RT_LO;  end
        CH_RT_HI:  begin st.wrChRtHi  = wr; st.rdSel = RD_CH_RT_HI;  end
        default: ;
      endcase
    end else if (!inChWin) begin
      unique case (busAddr)
        OFF_CAP_LO: st.rdSel = RD_CAP_LO;
        OFF_CAP_HI: st.rdSel = RD_CAP_HI;
        OFF_GCFG:   begin st.wrGcfg  = wr; st.rdSel = RD_GCFG;   end
        OFF_ISR:    begin st.wrIsr   = wr; st.rdSel = RD_ISR;    end
        OFF_CNT_LO: begin st.wrCntLo = wr; st.rdSel = RD_CNT_LO; end
        OFF_CNT_HI: begin st.wrCntHi = wr; st.rdSel = RD_CNT_HI; end
        default: ;
      endcase
    end
    // Sub-word reads return zero (R9)
    if (!wordOk) st.rdSel = RD_NONE;
  end

endmodule

// File: rtl/evtimer_regs_dp.sv
module evtimer_regs_dp
  import evtimer_regs_pkg::*;
#(
  parameter int              NumCh         = 3,
  parameter logic [31:0]     CLK_PERIOD_FS = 32'd10_000_000,
  parameter logic [31:0]     ROUTE_CAP     = 32'h0000_0004
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NumCh-1:0]      irqSet,
  output logic [DATA_W-1:0]     rdData,
  output logic [CNT_W-1:0]      counter,
  output logic                  globalEnable,
  output logic                  legacyRoute,
  output logic [NumCh*32-1:0]   chCfg,
  output logic [NumCh*64-1:0]   chCmp,
  output logic [NumCh*64-1:0]   chRoute,
  output logic [NumCh-1:0]      chArm,
  output logic [NumCh-1:0]      chDisarm,
  output logic [NumCh-1:0]      irqClear
);

  localparam logic [DATA_W-1:0] CapLo = CAP_BASE | (32'(NumCh - 1) << 8);

  logic [1:0]          gcfgQ;
  logic [NumCh-1:0]    isrQ;
  logic [CNT_W-1:0]    cntQ;
  logic [DATA_W-1:0]   cfgQ [NumCh];
  logic [63:0]         cmpQ [NumCh];
  logic [63:0]         rtQ  [NumCh];
  logic [NumCh-1:0]    programmed;
  logic [NumCh-1:0]    clrMask;
  logic                enRise, enFall;
  logic [DATA_W-1:0]   selCfg;
  logic [63:0]         selCmp, selRt;
  logic [DATA_W-1:0]   rdNext;

  assign globalEnable = gcfgQ[0];
  assign legacyRoute  = gcfgQ[1];
  assign counter      = cntQ;
  assign enRise       = st.wrGcfg &&  wrData[0] && !gcfgQ[0];
  assign enFall       = st.wrGcfg && !wrData[0] &&  gcfgQ[0];
  assign clrMask      = st.wrIsr ? wrData[NumCh-1:0] : '0;

  // Global configuration
  always_ff @(posedge clk) begin
    if (!rstN)          gcfgQ <= '0;
    else if (st.wrGcfg) gcfgQ <= wrData[1:0] & GCFG_WMASK;
  end

  // Main counter: runs while enabled, loadable per half only while held
  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (gcfgQ[0])      cntQ <= cntQ + 64'd1;
    else if (st.wrCntLo)    cntQ[31:0]  <= wrData;
    else if (st.wrCntHi)    cntQ[63:32] <= wrData;
  end

  // Interrupt status: set from channels wins over write-one clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isrQ     <= '0;
      irqClear <= '0;
    end else begin
      isrQ     <= (isrQ & ~clrMask) | irqSet;
      irqClear <= clrMask & isrQ;
    end
  end

  // Per-channel register groups
  for (genvar i = 0; i < NumCh; i++) begin : g_ch
    logic sel;
    assign sel = (st.chIdx == 5'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[i] <= '0;
        cmpQ[i] <= '1;
        rtQ[i]  <= '0;
      end else if (sel) begin
        if (st.wrChCfg)   cfgQ[i]        <= wrData & CH_CFG_WMASK;
        if (st.wrChCmpLo) cmpQ[i][31:0]  <= wrData;
        if (st.wrChCmpHi) cmpQ[i][63:32] <= wrData;
        if (st.wrChRtLo)  rtQ[i][31:0]   <= wrData;
        if (st.wrChRtHi)  rtQ[i][63:32]  <= wrData;
      end
    end

    assign programmed[i]           = (cmpQ[i] != '1);
    assign chCfg[i*32 +: 32]       = cfgQ[i];
    assign chCmp[i*64 +: 64]       = cmpQ[i];
    assign chRoute[i*64 +: 64]     = rtQ[i];
  end

  // Arm / disarm pulses on enable edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chArm    <= '0;
      chDisarm <= '0;
    end else begin
      chArm    <= enRise ? programmed : '0;
      chDisarm <= enFall ? '1 : '0;
    end
  end

  // Channel read select
  always_comb begin
    selCfg = '0;
    selCmp = '0;
    selRt  = '0;
    for (int i = 0; i < NumCh; i++) begin
      if (st.chIdx == 5'(i)) begin
        selCfg = cfgQ[i];
        selCmp = cmpQ[i];
        selRt  = rtQ[i];
      end
    end
  end

  always_comb begin
    unique case (st.rdSel)
      RD_CAP_LO:    rdNext = CapLo;
      RD_CAP_HI:    rdNext = CLK_PERIOD_FS;
      RD_GCFG:      rdNext = {30'd0, gcfgQ};
      RD_ISR:       rdNext = 32'(isrQ);
      RD_CNT_LO:    rdNext = cntQ[31:0];
      RD_CNT_HI:    rdNext = cntQ[63:32];
      RD_CH_CFG_LO: rdNext = selCfg | CH_CFG_RO;
      RD_CH_CFG_HI: rdNext = ROUTE_CAP;
      RD_CH_CMP_LO: rdNext = selCmp[31:0];
      RD_CH_CMP_HI: rdNext = selCmp[63:32];
      RD_CH_RT_LO:  rdNext = selRt[31:0];
      RD_CH_RT_HI:  rdNext = selRt[63:32];
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (st.rdStb) rdData <= rdNext;
  end

endmodule

// File: rtl/evtimer_regs.sv
module evtimer_regs
  import evtimer_regs_pkg::*;
#(
  parameter int          NUM_CH_CFG    = 3,
  parameter int          MAX_CH        = 8,
  parameter logic [31:0] CLK_PERIOD_FS = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP     = 32'h0000_0004,
  localparam int         NumCh         = clampCh(NUM_CH_CFG, MAX_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [9:0]          busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [1:0]          busSize,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NumCh-1:0]    irqSet,
  output logic                globalEnable,
  output logic                legacyRoute,
  output logic [63:0]         counter,
  output logic [NumCh*32-1:0] chCfg,
  output logic [NumCh*64-1:0] chCmp,
  output logic [NumCh*64-1:0] chRoute,
  output logic [NumCh-1:0]    chArm,
  output logic [NumCh-1:0]    chDisarm,
  output logic [NumCh-1:0]    irqClear
);

  strobes_t st;

  evtimer_regs_ctrl #(.NumCh(NumCh)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busSize (busSize),
    .st      (st)
  );

  evtimer_regs_dp #(
    .NumCh         (NumCh),
    .CLK_PERIOD_FS (CLK_PERIOD_FS),
    .ROUTE_CAP     (ROUTE_CAP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .wrData       (busWrData),
    .irqSet       (irqSet),
    .rdData       (busRdData),
    .counter      (counter),
    .globalEnable (globalEnable),
    .legacyRoute  (legacyRoute),
    .chCfg        (chCfg),
    .chCmp        (chCmp),
    .chRoute      (chRoute),
    .chArm        (chArm),
    .chDisarm     (chDisarm),
    .irqClear     (irqClear)
  );

endmodule

// File: rtl/evtimer_regs_checker.sv
module evtimer_regs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic        globalEnable,
  input logic [63:0] counter,
  input logic        anyArm,
  input logic        anyDisarm,
  input logic        anyClear
);

  // R5: one step per clock while running
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(globalEnable) |-> counter == $past(counter) + 64'd1);

  // R5 / R6: held value only moves through a bus write
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(globalEnable) && !$past(busWrEn)) |-> $stable(counter));

  // R7: arm pulses only follow a rising enable
  assert_arm_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyArm |-> $rose(globalEnable));

  // R7: disarm pulses only follow a falling enable
  assert_disarm_on_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyDisarm |-> $fell(globalEnable));

  // R8: an acknowledge pulse needs a bus write one cycle earlier
  assert_clear_from_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyClear |-> $past(busWrEn));

  // R7: never arm and disarm together
  assert_arm_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(anyArm && anyDisarm));

endmodule

bind evtimer_regs evtimer_regs_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .busWrEn      (busWrEn),
  .globalEnable (globalEnable),
  .counter      (counter),
  .anyArm       (|chArm),
  .anyDisarm    (|chDisarm),
  .anyClear     (|irqClear)
);

// File: tb/evtimer_regs_bench.sv
module evtimer_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [9:0]        busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [1:0]        busSize = 2'b10;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NCH-1:0]    irqSet = '0;
  logic              globalEnable, legacyRoute;
  logic [63:0]       counter;
  logic [NCH*32-1:0] chCfg;
  logic [NCH*64-1:0] chCmp, chRoute;
  logic [NCH-1:0]    chArm, chDisarm, irqClear;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtimer_regs u_evtimer_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busSize(busSize), .busWrData(busWrData),
    .busRdData(busRdData), .irqSet(irqSet), .globalEnable(globalEnable),
    .legacyRoute(legacyRoute), .counter(counter), .chCfg(chCfg),
    .chCmp(chCmp), .chRoute(chRoute), .chArm(chArm), .chDisarm(chDisarm),
    .irqClear(irqClear)
  );

  typedef struct packed {
    logic        isWr;
    logic [9:0]  addr;
    logic [31:0] data;   // write data, or expected read value
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'h000, 32'h8086_A201},  // R1 id word, count-1 = 2
    '{1'b0, 10'h004, 32'h0098_9680},  // R1 tick period
    '{1'b0, 10'h010, 32'h0000_0000},  // R12 config reset
    '{1'b0, 10'h020, 32'h0000_0000},  // R12 status reset
    '{1'b0, 10'h108, 32'hFFFF_FFFF},  // R12 comparator reset
    '{1'b1, 10'h100, 32'hFFFF_FFFF},
    '{1'b0, 10'h100, 32'h0000_7F7E},  // R4 mask + read-only bits
    '{1'b1, 10'h104, 32'h1234_5678},
    '{1'b0, 10'h104, 32'h0000_0004},  // R4 high word read-only
    '{1'b1, 10'h130, 32'hCAFE_0001},
    '{1'b0, 10'h130, 32'hCAFE_0001},  // R2 channel 1 route low
    '{1'b1, 10'h160, 32'hFFFF_FFFF},
    '{1'b0, 10'h160, 32'h0000_0000},  // R2 channel 3 absent
    '{1'b1, 10'h010, 32'hFFFF_FFFC},
    '{1'b0, 10'h010, 32'h0000_0000},  // R3 only two bits kept
    '{1'b1, 10'h010, 32'h0000_0002},
    '{1'b0, 10'h010, 32'h0000_0002},  // R3 legacy bit
    '{1'b0, 10'h014, 32'h0000_0000},  // R3 high word zero
    '{1'b1, 10'h050, 32'h0000_AAAA},
    '{1'b0, 10'h050, 32'h0000_0000},  // R10 undefined offset
    '{1'b0, 10'h128, 32'hFFFF_FFFF}   // R12 channel 1 comparator
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic busWrite(input logic [9:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
    busAddr = a; busWrData = d; busSize = sz; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busSize = 2'b10;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
    busAddr = a; busSize = sz; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; busSize = 2'b10;
    d = busRdData;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 / R11 reset state at the ports
    check("R12 rdData", busRdData, 0);
    check("R12 arm", chArm, 0);
    check("R12 disarm", chDisarm, 0);
    check("R12 clear", irqClear, 0);
    check("R12 enable", globalEnable, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) busWrite(VECS[i].addr, VECS[i].data);
      else begin
        busRead(VECS[i].addr, rd);
        check($sformatf("vector %0d addr 0x%0h", i, VECS[i].addr), rd, VECS[i].data);
      end
    end

    // R11 read data holds without a read strobe
    repeat (3) @(negedge clk);
    check("R11 hold", busRdData, 32'hFFFF_FFFF);

    // R7 arm only programmed channel 1
    busWrite(10'h128, 32'h0000_0100);
    busWrite(10'h0F0, 32'h0000_0010);
    busWrite(10'h0F4, 32'h0000_0001);
    busWrite(10'h010, 32'h0000_0001);
    check("R7 arm", chArm, 3'b010);
    repeat (9) @(negedge clk);
    check("R7 arm one cycle", chArm, 0);
    busWrite(10'h010, 32'h0000_0000);
    check("R7 disarm", chDisarm, 3'b111);
    busRead(10'h0F0, rd); check("R5 count low", rd, 32'h1A);
    busRead(10'h0F4, rd); check("R5 count high", rd, 32'h1);

    // R5 carry into high half
    busWrite(10'h0F0, 32'hFFFF_FFFF);
    busWrite(10'h0F4, 32'h0);
    busWrite(10'h010, 32'h1);
    busWrite(10'h010, 32'h0);
    busRead(10'h0F0, rd); check("R5 carry low", rd, 32'h0);
    busRead(10'h0F4, rd); check("R5 carry high", rd, 32'h1);

    // R6 load ignored while enabled
    busWrite(10'h0F0, 32'h0);
    busWrite(10'h0F4, 32'h0);
    busWrite(10'h010, 32'h1);
    busWrite(10'h0F0, 32'h0000_5000);
    busWrite(10'h010, 32'h0);
    busRead(10'h0F0, rd); check("R6 load ignored", rd, 32'h2);

    // R5 live read, then hold while disabled
    busWrite(10'h0F0, 32'h0);
    busWrite(10'h010, 32'h1);
    repeat (4) @(negedge clk);
    busRead(10'h0F0, rd); check("R5 live read", rd, 32'h4);
    busWrite(10'h010, 32'h0);
    repeat (5) @(negedge clk);
    busRead(10'h0F0, rd); check("R5 held", rd, 32'h6);

    // R8 status set and write-one clear
    irqSet = 3'b101;
    @(negedge clk);
    irqSet = 3'b000;
    busRead(10'h020, rd); check("R8 status set", rd, 32'h5);
    busWrite(10'h020, 32'h3);
    check("R8 clear pulse", irqClear, 3'b001);
    busRead(10'h020, rd); check("R8 status after clear", rd, 32'h4);
    irqSet = 3'b100;
    busWrite(10'h020, 32'h4);
    irqSet = 3'b000;
    busRead(10'h020, rd); check("R8 set wins", rd, 32'h4);

    // R9 sub-word accesses
    busWrite(10'h010, 32'h1, 2'b00);
    check("R9 byte write ignored", globalEnable, 1'b0);
    busRead(10'h000, rd, 2'b01); check("R9 halfword read", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule